// File: doc/BRIEF.md
# Raster Timing Generator with Separate Data-Valid Window

This block produces the raster timing for a display interface: horizontal and vertical sync, an active-video enable, and a data-valid enable that can be shorter than the active window. It computes every edge position from the programmed sync, porch and active sizes. A line is split into sync, back porch, active and front porch regions. A frame is split the same way in lines. The vertical display window is placed on a linear clock count from frame start, which allows a per-frame skew.

The data-valid window always opens on the same pixel as the active window. Its length depends on the stream mode. A compressed stream carries one clock per three compressed bytes. Packing two pixels per clock halves that length, and it also halves the uncompressed length on serial interfaces. A host loads all settings with a one-cycle start strobe. The settings then stay fixed until the next strobe. A setting that cannot produce a legal raster raises an error flag and keeps the outputs quiet.

Top module: `vtg_top`

## Requirements
- R1: The line period is `hpw+hbp+hact+hfp` clocks and the frame period is `vpw+vbp+vact+vfp` lines. Horizontal sync is asserted on the first `hpw` clocks of each line and vertical sync on the first `vpw` lines of each frame. The raster wraps at the end of each frame.
- R2: Active enable is high only on horizontal positions from `hpw+hbp` through `line-hfp-1`, and only inside the vertical display window.
- R3: For interface modes other than DP, the vertical display window covers linear clock counts from `(vpw+vbp)*line+skew` through `(frame-vfp)*line+skew-1`, counted from frame start.
- R4: In DP mode (`iface_i`=1), the vertical window start moves later by `hpw+hbp` clocks and its end moves earlier by `hfp` clocks.
- R5: With compression on, the data length is `ceil(line_bytes/3)` clocks. With two-pixel packing also on, the length is halved with the remainder dropped.
- R6: With compression off, the data length is `hact`. It is `floor(hact/2)` when packing is on and the mode is not DP.
- R7: With compression on and packing off, data-valid is identical to active enable on every cycle.
- R8: In HDMI mode (`iface_i`=2), both syncs are active-high when `vact` is 720 or more and active-low otherwise. All other modes use active-high syncs. Codes 0 and 3 select the generic serial mode.
- R9: If the line period or the frame period is zero or overflows, or the data length exceeds `hact`, the cycle after start asserts `err_o`. Active and data-valid enables then stay low and both syncs hold their inactive level until a start with legal settings.
- R10: After reset and before the first start, all enables are low, syncs are at logic 0, and `err_o` is low.
- R11: Data-valid is never high while active enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load settings and restart the raster |
| iface_i | input | 2 | Interface mode: 0 serial, 1 DP, 2 HDMI |
| comp_en_i | input | 1 | Compressed stream |
| wide_en_i | input | 1 | Two pixels per clock |
| hpw_i | input | H_W | Horizontal sync width |
| hbp_i | input | H_W | Horizontal back porch |
| hact_i | input | H_W | Active width |
| hfp_i | input | H_W | Horizontal front porch |
| vpw_i | input | V_W | Vertical sync width in lines |
| vbp_i | input | V_W | Vertical back porch |
| vact_i | input | V_W | Active height |
| vfp_i | input | V_W | Vertical front porch |
| skew_i | input | H_W | Display window skew in clocks |
| line_bytes_i | input | B_W | Compressed bytes per line |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| act_o | output | 1 | Active-video enable |
| dv_o | output | 1 | Data-valid enable |
| err_o | output | 1 | Settings rejected |

## Verification
Four properties are checked on every cycle: the data-valid enable lies inside the active window, active video never overlaps either sync pulse, a rejected setting keeps everything quiet, and nothing is enabled before a legal start. These invariants cannot show where the edges fall. The directed scenarios check placement by comparing every cycle of a frame and a following line against positions computed from the formulas. They cover all four combinations of compression and packing, the DP shift, both HDMI polarities, exact and rounded byte counts, and the rejection and recovery cases.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  typedef enum logic [1:0] {
    IF_SERIAL = 2'd0,
    IF_DP     = 2'd1,
    IF_HDMI   = 2'd2,
    IF_RSVD   = 2'd3
  } iface_e;

  localparam int HDMI_POS_LINES = 720;
endpackage

// File: rtl/vtg_calc.sv
module vtg_calc
  import vtg_pkg::*;
#(
  parameter int H_W = 16,
  parameter int V_W = 16,
  parameter int B_W = 16,
  parameter int P_W = H_W + V_W + 2
) (
  input  iface_e         iface_i,
  input  logic           comp_i,
  input  logic           wide_i,
  input  logic [H_W-1:0] hpw_i,
  input  logic [H_W-1:0] hbp_i,
  input  logic [H_W-1:0] hact_i,
  input  logic [H_W-1:0] hfp_i,
  input  logic [V_W-1:0] vpw_i,
  input  logic [V_W-1:0] vbp_i,
  input  logic [V_W-1:0] vact_i,
  input  logic [V_W-1:0] vfp_i,
  input  logic [H_W-1:0] skew_i,
  input  logic [B_W-1:0] bytes_i,
  output logic [H_W-1:0] line_o,
  output logic [V_W-1:0] frame_o,
  output logic [H_W-1:0] h_beg_o,
  output logic [H_W-1:0] h_end_o,
  output logic [P_W-1:0] v_beg_o,
  output logic [P_W-1:0] v_end_o,
  output logic [P_W-1:0] dlen_o,
  output logic           sep_o,
  output logic           inv_o,
  output logic           bad_o
);
  logic [H_W+1:0] line_x;
  logic [V_W+1:0] frame_x;
  logic [B_W+1:0] b3;
  logic [P_W-1:0] vpre, vpost;
  logic           dp, hdmi;

  assign dp      = (iface_i == IF_DP);
  assign hdmi    = (iface_i == IF_HDMI);
  assign line_x  = (H_W+2)'(hpw_i) + (H_W+2)'(hbp_i) + (H_W+2)'(hact_i) + (H_W+2)'(hfp_i);
  assign frame_x = (V_W+2)'(vpw_i) + (V_W+2)'(vbp_i) + (V_W+2)'(vact_i) + (V_W+2)'(vfp_i);
  assign line_o  = line_x[H_W-1:0];
  assign frame_o = frame_x[V_W-1:0];
  assign h_beg_o = hpw_i + hbp_i;
  assign h_end_o = line_o - hfp_i - H_W'(1);

  assign vpre    = P_W'(vpw_i) + P_W'(vbp_i);
  assign vpost   = P_W'(frame_o) - P_W'(vfp_i);
  // DP shifts the vertical window by horizontal blanking amounts
  assign v_beg_o = vpre * P_W'(line_o) + P_W'(skew_i)
                 + (dp ? P_W'(hpw_i) + P_W'(hbp_i) : '0);
  assign v_end_o = vpost * P_W'(line_o) + P_W'(skew_i) - P_W'(1)
                 - (dp ? P_W'(hfp_i) : '0);

  assign b3 = ((B_W+2)'(bytes_i) + (B_W+2)'(2)) / (B_W+2)'(3);

  always_comb begin
    if (comp_i)                dlen_o = wide_i ? P_W'(b3 >> 1) : P_W'(b3);
    else if (wide_i && !dp)    dlen_o = P_W'(hact_i >> 1);
    else                       dlen_o = P_W'(hact_i);
  end

  assign sep_o = !comp_i || wide_i;
  assign inv_o = hdmi && (vact_i < V_W'(HDMI_POS_LINES));
  assign bad_o = (line_x == '0) || (line_x[H_W+1:H_W] != 2'b00)
              || (frame_x == '0) || (frame_x[V_W+1:V_W] != 2'b00)
              || (dlen_o > P_W'(hact_i));
endmodule

// File: rtl/vtg_raster.sv
module vtg_raster #(
  parameter int H_W = 16,
  parameter int V_W = 16,
  parameter int P_W = H_W + V_W + 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           en_i,
  input  logic [H_W-1:0] line_i,
  input  logic [V_W-1:0] frame_i,
  output logic [H_W-1:0] h_o,
  output logic [V_W-1:0] v_o,
  output logic [P_W-1:0] pos_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_o   <= '0;
      v_o   <= '0;
      pos_o <= '0;
    end else if (clr_i) begin
      h_o   <= '0;
      v_o   <= '0;
      pos_o <= '0;
    end else if (en_i) begin
      if (h_o == line_i - H_W'(1)) begin
        h_o <= '0;
        if (v_o == frame_i - V_W'(1)) begin
          v_o   <= '0;
          pos_o <= '0;
        end else begin
          v_o   <= v_o + V_W'(1);
          pos_o <= pos_o + P_W'(1);
        end
      end else begin
        h_o   <= h_o + H_W'(1);
        pos_o <= pos_o + P_W'(1);
      end
    end
  end
endmodule

// File: rtl/vtg_top.sv
module vtg_top
  import vtg_pkg::*;
#(
  parameter int H_W = 16,
  parameter int V_W = 16,
  parameter int B_W = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [1:0]     iface_i,
  input  logic           comp_en_i,
  input  logic           wide_en_i,
  input  logic [H_W-1:0] hpw_i,
  input  logic [H_W-1:0] hbp_i,
  input  logic [H_W-1:0] hact_i,
  input  logic [H_W-1:0] hfp_i,
  input  logic [V_W-1:0] vpw_i,
  input  logic [V_W-1:0] vbp_i,
  input  logic [V_W-1:0] vact_i,
  input  logic [V_W-1:0] vfp_i,
  input  logic [H_W-1:0] skew_i,
  input  logic [B_W-1:0] line_bytes_i,
  output logic           hsync_o,
  output logic           vsync_o,
  output logic           act_o,
  output logic           dv_o,
  output logic           err_o
);
  localparam int P_W = H_W + V_W + 2;

  iface_e         iface_q;
  logic           comp_q, wide_q, run_q;
  logic [H_W-1:0] hpw_q, hbp_q, hact_q, hfp_q, skew_q;
  logic [V_W-1:0] vpw_q, vbp_q, vact_q, vfp_q;
  logic [B_W-1:0] bytes_q;

  logic [H_W-1:0] line, h_beg, h_end, h;
  logic [V_W-1:0] frame, v;
  logic [P_W-1:0] v_beg, v_end, dlen, pos;
  logic           sep_en, sync_inv, bad, go;
  logic           h_in, v_in, d_in;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iface_q <= IF_SERIAL;
      comp_q  <= 1'b0;
      wide_q  <= 1'b0;
      run_q   <= 1'b0;
      hpw_q   <= '0;
      hbp_q   <= '0;
      hact_q  <= '0;
      hfp_q   <= '0;
      skew_q  <= '0;
      vpw_q   <= '0;
      vbp_q   <= '0;
      vact_q  <= '0;
      vfp_q   <= '0;
      bytes_q <= '0;
    end else if (start_i) begin
      iface_q <= iface_e'(iface_i);
      comp_q  <= comp_en_i;
      wide_q  <= wide_en_i;
      run_q   <= 1'b1;
      hpw_q   <= hpw_i;
      hbp_q   <= hbp_i;
      hact_q  <= hact_i;
      hfp_q   <= hfp_i;
      skew_q  <= skew_i;
      vpw_q   <= vpw_i;
      vbp_q   <= vbp_i;
      vact_q  <= vact_i;
      vfp_q   <= vfp_i;
      bytes_q <= line_bytes_i;
    end
  end

  vtg_calc #(.H_W(H_W), .V_W(V_W), .B_W(B_W), .P_W(P_W)) u_calc (
    .iface_i (iface_q),
    .comp_i  (comp_q),
    .wide_i  (wide_q),
    .hpw_i   (hpw_q),
    .hbp_i   (hbp_q),
    .hact_i  (hact_q),
    .hfp_i   (hfp_q),
    .vpw_i   (vpw_q),
    .vbp_i   (vbp_q),
    .vact_i  (vact_q),
    .vfp_i   (vfp_q),
    .skew_i  (skew_q),
    .bytes_i (bytes_q),
    .line_o  (line),
    .frame_o (frame),
    .h_beg_o (h_beg),
    .h_end_o (h_end),
    .v_beg_o (v_beg),
    .v_end_o (v_end),
    .dlen_o  (dlen),
    .sep_o   (sep_en),
    .inv_o   (sync_inv),
    .bad_o   (bad)
  );

  // settings are judged one cycle after start; a bad set never runs
  assign go    = run_q && !bad;
  assign err_o = run_q && bad;

  vtg_raster #(.H_W(H_W), .V_W(V_W), .P_W(P_W)) u_raster (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (start_i),
    .en_i    (go),
    .line_i  (line),
    .frame_i (frame),
    .h_o     (h),
    .v_o     (v),
    .pos_o   (pos)
  );

  assign h_in = (h >= h_beg) && (h <= h_end);
  assign v_in = (pos >= v_beg) && (pos <= v_end);
  assign d_in = (h >= h_beg) && (P_W'(h - h_beg) < dlen);

  assign act_o   = go && h_in && v_in;
  assign dv_o    = sep_en ? (go && d_in && v_in) : act_o;
  assign hsync_o = (go && (h < hpw_q)) ^ sync_inv;
  assign vsync_o = (go && (v < vpw_q)) ^ sync_inv;
endmodule

// File: rtl/vtg_chk.sv
module vtg_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic hsync_o,
  input logic vsync_o,
  input logic act_o,
  input logic dv_o,
  input logic err_o,
  input logic sync_inv,
  input logic go
);
  AST_DV_INSIDE_ACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dv_o |-> act_o); // R11

  AST_ERR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!act_o && !dv_o && hsync_o == sync_inv && vsync_o == sync_inv)); // R9

  AST_ACT_OFF_HSYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_o |-> (hsync_o == sync_inv)); // R2

  AST_ACT_OFF_VSYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_o |-> (vsync_o == sync_inv)); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !go |-> (!act_o && !dv_o)); // R10
endmodule

bind vtg_top vtg_chk u_chk (.*);

// File: tb/sim_vtg_top.sv
module sim_vtg_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  iface_i = 2'd0;
  logic        comp_en_i = 1'b0, wide_en_i = 1'b0;
  logic [15:0] hpw_i = '0, hbp_i = '0, hact_i = '0, hfp_i = '0, skew_i = '0;
  logic [15:0] vpw_i = '0, vbp_i = '0, vact_i = '0, vfp_i = '0;
  logic [15:0] line_bytes_i = '0;
  logic        hsync_o, vsync_o, act_o, dv_o, err_o;

  int n_chk = 0;
  int n_fail = 0;

  vtg_top u0 (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic load(int ifc, int comp, int wide, int hpw, int hbp, int ha, int hfp,
                      int vpw, int vbp, int va, int vfp, int skew, int bytes);
    @(negedge clk_i);
    iface_i = 2'(ifc); comp_en_i = 1'(comp); wide_en_i = 1'(wide);
    hpw_i = 16'(hpw); hbp_i = 16'(hbp); hact_i = 16'(ha); hfp_i = 16'(hfp);
    vpw_i = 16'(vpw); vbp_i = 16'(vbp); vact_i = 16'(va); vfp_i = 16'(vfp);
    skew_i = 16'(skew); line_bytes_i = 16'(bytes);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  // runs one frame plus one line and compares each cycle with the formulas
  task automatic run_frame(string tag, int ifc, int comp, int wide, int hpw, int hbp,
                           int ha, int hfp, int vpw, int vbp, int va, int vfp,
                           int skew, int bytes);
    int line, frame, fclk, vb, ve, hb, he, dl, inv;
    int bad_hs, bad_vs, bad_act, bad_dv, bad_in;
    bit dp;
    load(ifc, comp, wide, hpw, hbp, ha, hfp, vpw, vbp, va, vfp, skew, bytes);
    dp    = (ifc == 1);
    line  = hpw + hbp + ha + hfp;
    frame = vpw + vbp + va + vfp;
    fclk  = line * frame;
    hb = hpw + hbp;
    he = line - hfp - 1;
    vb = (vpw + vbp) * line + skew;
    ve = (frame - vfp) * line + skew - 1;
    if (dp) begin vb += hpw + hbp; ve -= hfp; end
    if (comp != 0)                dl = ((bytes + 2) / 3) >> wide;
    else if (wide != 0 && !dp)    dl = ha / 2;
    else                          dl = ha;
    inv = (ifc == 2 && va < 720) ? 1 : 0;
    bad_hs = 0; bad_vs = 0; bad_act = 0; bad_dv = 0; bad_in = 0;
    chk(tag, "err_o after legal start", int'(err_o), 0);
    for (int k = 0; k < fclk + line; k++) begin
      int kk, h, v, e_hs, e_vs, e_act, e_dv, vin;
      kk = k % fclk;
      h  = kk % line;
      v  = kk / line;
      vin   = (kk >= vb && kk <= ve) ? 1 : 0;
      e_hs  = ((h < hpw) ? 1 : 0) ^ inv;
      e_vs  = ((v < vpw) ? 1 : 0) ^ inv;
      e_act = (vin == 1 && h >= hb && h <= he) ? 1 : 0;
      if (comp != 0 && wide == 0) e_dv = e_act;
      else e_dv = (vin == 1 && h >= hb && h < hb + dl) ? 1 : 0;
      if (int'(hsync_o) != e_hs) bad_hs++;
      if (int'(vsync_o) != e_vs) bad_vs++;
      if (int'(act_o) != e_act) bad_act++;
      if (int'(dv_o) != e_dv) bad_dv++;
      if (dv_o && !act_o) bad_in++;
      @(negedge clk_i);
    end
    chk({tag, " R1"}, "hsync mismatch cycles", bad_hs, 0);
    chk({tag, " R1"}, "vsync mismatch cycles", bad_vs, 0);
    chk({tag, " R2"}, "active mismatch cycles", bad_act, 0);
    chk(tag, "data-valid mismatch cycles", bad_dv, 0);
    chk("R11", "data-valid outside active cycles", bad_in, 0);
  endtask

  task automatic t_reset();
    chk("R10", "hsync at reset", int'(hsync_o), 0);
    chk("R10", "vsync at reset", int'(vsync_o), 0);
    chk("R10", "act at reset", int'(act_o), 0);
    chk("R10", "dv at reset", int'(dv_o), 0);
    chk("R10", "err at reset", int'(err_o), 0);
  endtask

  task automatic t_reject(string what, int ifc, int comp, int wide, int hpw, int hbp,
                          int ha, int hfp, int vpw, int vbp, int va, int vfp, int bytes,
                          int inv);
    int quiet;
    load(ifc, comp, wide, hpw, hbp, ha, hfp, vpw, vbp, va, vfp, 0, bytes);
    chk("R9", {what, " err_o"}, int'(err_o), 1);
    quiet = 0;
    for (int k = 0; k < 60; k++) begin
      if (act_o || dv_o || int'(hsync_o) != inv || int'(vsync_o) != inv) quiet++;
      @(negedge clk_i);
    end
    chk("R9", {what, " noisy cycles"}, quiet, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_reset();
    // R3 R6: plain serial, skew 1
    run_frame("R3 R6 plain", 0, 0, 0, 2, 3, 12, 2, 1, 2, 4, 2, 1, 0);
    // R6: two pixels per clock halves the data window
    run_frame("R6 wide", 0, 0, 1, 2, 3, 12, 2, 1, 2, 4, 2, 0, 0);
    // R5: 28 bytes -> 10 -> 5 clocks; 27 bytes -> 9 -> 4 clocks
    run_frame("R5 comp wide 28", 0, 1, 1, 2, 3, 12, 2, 1, 2, 4, 2, 2, 28);
    run_frame("R5 comp wide 27", 0, 1, 1, 2, 3, 12, 2, 1, 2, 4, 2, 0, 27);
    // R7: compressed, single pixel -> follows active
    run_frame("R7 comp narrow", 0, 1, 0, 2, 3, 12, 2, 1, 2, 4, 2, 0, 28);
    // R4 R6: DP keeps full width while packed
    run_frame("R4 R6 dp wide", 1, 0, 1, 2, 3, 12, 2, 1, 2, 4, 2, 0, 0);
    run_frame("R4 R5 dp comp", 1, 1, 1, 3, 2, 10, 3, 2, 1, 3, 1, 1, 31);
    // R8: HDMI polarity both sides of 720 lines
    run_frame("R8 hdmi low", 2, 0, 0, 2, 3, 12, 2, 1, 2, 4, 2, 0, 0);
    run_frame("R8 hdmi high", 2, 0, 0, 2, 3, 12, 2, 1, 2, 720, 2, 0, 0);
    // R9: rejection and recovery
    t_reject("data too long", 0, 1, 0, 2, 3, 12, 2, 1, 2, 4, 2, 40, 0);
    t_reject("zero line", 0, 0, 0, 0, 0, 0, 0, 1, 2, 4, 2, 0, 0);
    t_reject("zero frame hdmi", 2, 0, 0, 2, 3, 12, 2, 0, 0, 0, 0, 0, 1);
    run_frame("R9 recover", 0, 0, 0, 2, 3, 12, 2, 1, 2, 4, 2, 0, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule